// File: doc/BRIEF.md
# Telegram End-of-Message Length Counter

This block sits behind clock recovery in a telegram receiver. After the start-indicator matcher reports that the last bit of the start pattern has arrived, the block counts the data bits that follow. When the programmed number of data bits has passed, it raises a one-cycle end-of-message pulse. The length of the data field is held in an 8-bit writable register. Each telegram takes its count from the value in that register at the moment the start indicator is found.

The data-length rule is one of several end-of-message criteria a receiver may use. A select input picks which criterion is in force, and the block acts only when the data-length criterion is selected. A programmed value N ends the message on data bit N+1. A value of zero therefore means the very next data bit ends it, and never an immediate end.

Top module: `tel_eom_len`

## Requirements
- R1: After a synchronous reset the length register holds 0x00, and both `eom_pulse` and `busy` are low.
- R2: A write (`len_we` high) stores `len_wdata`. When `crit_sel` is 2'b01 (data-length mode), a TSI-found pulse loads that value N, and `eom_pulse` rises on data bit N+1 after the TSI. `eom_pulse` is registered: it is high in the cycle after the clock edge that samples the ending `bit_vld`.
- R3: A `bit_vld` strobe is counted only if it comes after the cycle of the TSI-found pulse. Strobes before the TSI, and a strobe in the same cycle as the TSI pulse, are not counted.
- R4: With length 0x00, the first data bit after the TSI produces `eom_pulse`.
- R5: With length 0xFF, `eom_pulse` is produced on the 256th data bit after the TSI.
- R6: `eom_pulse` lasts exactly one cycle, and `busy` falls in that same cycle. Afterwards further `bit_vld` strobes produce no pulse until a new TSI-found pulse arrives.
- R7: When `crit_sel` is not 2'b01, the block never asserts `eom_pulse`, and a TSI-found pulse leaves `busy` low.
- R8: A TSI-found pulse while counting restarts the count from the current register value.
- R9: A register write while counting does not change the ongoing count. It takes effect at the next TSI-found pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | One-cycle strobe per recovered bit |
| tsi_found | input | 1 | One-cycle pulse on the last bit of the start indicator |
| len_we | input | 1 | Write enable for the length register |
| len_wdata | input | 8 | Data-field length to store |
| crit_sel | input | 2 | End-of-message criterion; 2'b01 selects data length |
| eom_pulse | output | 1 | One-cycle end-of-message pulse |
| busy | output | 1 | High while a data-length count is running |

## Verification
A wrong remaining-bit count shows up at the ports as `eom_pulse` on the wrong bit. The error becomes visible one cycle after the strobe that should have ended the message, or after an early strobe that wrongly ends it. A stale armed state shows as `busy` stuck high or as a spurious pulse on later strobes. A wrongly latched length only becomes visible when the next telegram ends at the wrong bit. The bench therefore counts the bit at which each pulse appears, and it keeps strobing after the pulse.

// File: rtl/tel_eom_pkg.sv
package tel_eom_pkg;
  localparam int LEN_W = 8;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] CRIT_DATA_LEN = 2'd1;
endpackage

// File: rtl/tel_len_reg.sv
module tel_len_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/tel_crit_dec.sv
module tel_crit_dec #(
  parameter int                SW  = 2,
  parameter logic [SW-1:0]     SEL = '0
) (
  input  logic [SW-1:0] sel,
  output logic          hit
);
  always_comb hit = (sel == SEL);
endmodule

// File: rtl/tel_bit_cnt.sv
module tel_bit_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm_en,
  input  logic         tsi,
  input  logic         bit_stb,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         done
);
  logic [W-1:0] remain;
  logic         last_bit;

  always_comb last_bit = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tsi) begin
        active <= arm_en;
        remain <= load_val;
      end else if (active && bit_stb) begin
        if (last_bit) begin
          active <= 1'b0;
          done   <= arm_en;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tel_eom_len.sv
module tel_eom_len
  import tel_eom_pkg::*;
#(
  parameter int LW = LEN_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_vld,
  input  logic          tsi_found,
  input  logic          len_we,
  input  logic [LW-1:0] len_wdata,
  input  logic [SW-1:0] crit_sel,
  output logic          eom_pulse,
  output logic          busy
);
  logic [LW-1:0] len_q;
  logic          len_mode;

  tel_len_reg #(.W(LW)) u_len (
    .clk(clk), .rst(rst), .we(len_we), .wdata(len_wdata), .q(len_q)
  );

  tel_crit_dec #(.SW(SW), .SEL(SW'(CRIT_DATA_LEN))) u_dec (
    .sel(crit_sel), .hit(len_mode)
  );

  tel_bit_cnt #(.W(LW)) u_cnt (
    .clk(clk), .rst(rst), .arm_en(len_mode), .tsi(tsi_found),
    .bit_stb(bit_vld), .load_val(len_q), .active(busy), .done(eom_pulse)
  );
endmodule

// File: rtl/tel_eom_len_chk.sv
module tel_eom_len_chk
  import tel_eom_pkg::*;
#(
  parameter int LW = LEN_W,
  parameter int SW = SEL_W
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_vld,
  input logic          tsi_found,
  input logic [SW-1:0] crit_sel,
  input logic          eom_pulse,
  input logic          busy
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!eom_pulse && !busy));

  p_eom_from_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    eom_pulse |-> ($past(busy) && $past(bit_vld) && !$past(tsi_found)));

  p_eom_single_r6: assert property (@(posedge clk) disable iff (rst)
    eom_pulse |=> !eom_pulse);

  p_eom_idle_r6: assert property (@(posedge clk) disable iff (rst)
    eom_pulse |-> !busy);

  p_eom_mode_r7: assert property (@(posedge clk) disable iff (rst)
    eom_pulse |-> ($past(crit_sel) == SW'(CRIT_DATA_LEN)));

  p_no_arm_r7: assert property (@(posedge clk) disable iff (rst)
    (tsi_found && crit_sel != SW'(CRIT_DATA_LEN)) |=> (!busy && !eom_pulse));

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (tsi_found && crit_sel == SW'(CRIT_DATA_LEN)) |=> (busy && !eom_pulse));
endmodule

bind tel_eom_len tel_eom_len_chk #(.LW(LW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .tsi_found(tsi_found),
  .crit_sel(crit_sel), .eom_pulse(eom_pulse), .busy(busy)
);

// File: tb/tel_eom_len_bench.sv
module tel_eom_len_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld = 1'b0;
  logic       tsi_found = 1'b0;
  logic       len_we = 1'b0;
  logic [7:0] len_wdata = 8'h00;
  logic [1:0] crit_sel = 2'b01;
  logic       eom_pulse, busy;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tel_eom_len u_tel_eom_len (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .tsi_found(tsi_found),
    .len_we(len_we), .len_wdata(len_wdata), .crit_sel(crit_sel),
    .eom_pulse(eom_pulse), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_len(input logic [7:0] v);
    @(negedge clk); len_we = 1'b1; len_wdata = v;
    @(negedge clk); len_we = 1'b0;
  endtask

  task automatic tsi(input bit with_bit);
    @(negedge clk); tsi_found = 1'b1; bit_vld = with_bit;
    @(negedge clk); tsi_found = 1'b0; bit_vld = 1'b0;
  endtask

  // one data bit; returns eom as seen after the sampling edge
  task automatic one_bit(output bit e);
    @(negedge clk); bit_vld = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
    e = eom_pulse;
  endtask

  // sends n bits, reports bit index of first eom (0 = none) and pulse count
  task automatic run_bits(input int n, output int first, output int pulses);
    bit e;
    first = 0; pulses = 0;
    for (int i = 1; i <= n; i++) begin
      one_bit(e);
      if (e) begin
        pulses++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic t_reset();
    idle(1);
    chk(eom_pulse == 1'b0, "R1 eom", eom_pulse, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    rst = 1'b0;
    tsi(1'b0);
    begin
      int f, p;
      run_bits(3, f, p);
      chk(f == 1, "R1 reset length zero", f, 1);
    end
  endtask

  task automatic t_len(input logic [7:0] n, input string req);
    int f, p;
    wr_len(n);
    tsi(1'b0);
    chk(busy == 1'b1, {req, " armed"}, busy, 1);
    run_bits(int'(n) + 4, f, p);
    chk(f == int'(n) + 1, {req, " eom bit"}, f, int'(n) + 1);
    chk(p == 1, {req, " R6 pulse count"}, p, 1);
  endtask

  task automatic t_pulse_shape();
    bit e;
    wr_len(8'd2);
    tsi(1'b0);
    one_bit(e); one_bit(e);
    @(negedge clk); bit_vld = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
    chk(eom_pulse == 1'b1, "R2 eom after edge", eom_pulse, 1);
    chk(busy == 1'b0, "R6 busy falls with eom", busy, 0);
    @(negedge clk);
    chk(eom_pulse == 1'b0, "R6 single cycle", eom_pulse, 0);
  endtask

  task automatic t_pre_tsi();
    int f, p;
    wr_len(8'd3);
    run_bits(5, f, p);
    chk(p == 0 && busy == 1'b0, "R3 bits before tsi", p, 0);
    tsi(1'b1);
    run_bits(6, f, p);
    chk(f == 4, "R3 tsi-cycle bit not counted", f, 4);
  endtask

  task automatic t_mode();
    int f, p;
    wr_len(8'd1);
    crit_sel = 2'b00;
    tsi(1'b0);
    chk(busy == 1'b0, "R7 no arm mode0", busy, 0);
    run_bits(4, f, p);
    chk(p == 0, "R7 no eom mode0", p, 0);
    crit_sel = 2'b11;
    tsi(1'b0);
    run_bits(4, f, p);
    chk(p == 0 && busy == 1'b0, "R7 no eom mode3", p, 0);
    crit_sel = 2'b01;
    tsi(1'b0);
    run_bits(1, f, p);
    crit_sel = 2'b10;
    run_bits(3, f, p);
    chk(p == 0, "R7 mode change mid count", p, 0);
    crit_sel = 2'b01;
  endtask

  task automatic t_restart();
    int f, p;
    wr_len(8'd4);
    tsi(1'b0);
    run_bits(3, f, p);
    tsi(1'b0);
    run_bits(8, f, p);
    chk(f == 5, "R8 restart count", f, 5);
  endtask

  task automatic t_write_mid();
    int f, p;
    wr_len(8'd5);
    tsi(1'b0);
    run_bits(2, f, p);
    wr_len(8'd1);
    run_bits(6, f, p);
    chk(f == 4, "R9 count unchanged by write", f, 4);
    tsi(1'b0);
    run_bits(4, f, p);
    chk(f == 2, "R9 new length at next tsi", f, 2);
  endtask

  initial begin
    rst = 1'b1;
    idle(2);
    t_reset();
    t_len(8'd0, "R4");
    t_len(8'd7, "R2");
    t_len(8'd255, "R5");
    t_pulse_shape();
    t_pre_tsi();
    t_mode();
    t_restart();
    t_write_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule